// File: doc/BRIEF.md
# Differential QPSK Dibit Decoder and Serializer

This block sits after the symbol slicer of a QPSK receiver. Each received symbol arrives as a 2-bit quadrant index with a one-cycle strobe. The block does not use the absolute phase. It takes the rotation from the previous quadrant to the current one, turns that rotation into a transmitted bit pair, and sends the two bits out one after the other on a single serial line. The line runs at twice the symbol rate and comes with a recovered bit clock and a valid flag.

A mode input picks between two rotation tables. The second table swaps the two quarter-turn entries. Use it when the front end processes a spectrally inverted image of the carrier, which reverses the sense of rotation. The first strobe after reset only sets the phase reference. Each bit lasts `BIT_CYCLES` clock cycles. The bit clock is low in the first half of each bit and high in the second half, so a downstream register can capture the data on the rising edge of the bit clock.

Top module: `dqpsk_dibit_serializer`

## Requirements
- R1: The decoded pair depends only on the rotation step `(current - previous) mod 4`. Quadrants count counterclockwise 0..3, so step 1 is +90°, step 2 is 180° and step 3 is −90°.
- R2: With `spec_inv` = 0, the steps decode as follows: step 0 gives pair `00`, step 3 gives `01`, step 1 gives `10` and step 2 gives `11`.
- R3: With `spec_inv` = 1, step 1 gives `01` and step 3 gives `10`. Steps 0 and 2 decode as in R2. `spec_inv` is sampled on the same edge as the strobe.
- R4: The first strobe after reset loads the reference quadrant and produces no serial bits.
- R5: The left bit of each pair goes out first and the right bit second. Each bit is held on `ser_data` for `BIT_CYCLES` cycles while `ser_valid` is 1.
- R6: `ser_clk` is 0 for the first `BIT_CYCLES/2` cycles of each bit and 1 for the rest of the bit. `ser_data` changes only while `ser_clk` is 0, so it is stable across each rising edge of `ser_clk`.
- R7: Latency: `ser_valid` rises right after the second rising clock edge that follows the edge sampling a decoding strobe. At that point `ser_clk` is 0.
- R8: When strobes come exactly `2*BIT_CYCLES` cycles apart, consecutive pairs form one unbroken stream. `ser_valid` stays high for `2*BIT_CYCLES` cycles per pair.
- R9: While no bit is being sent, and in the reset state, `ser_valid`, `ser_clk` and `ser_data` are all 0.
- R10: Strobes must be at least `2*BIT_CYCLES` cycles apart. Under that rule a decoded pair never overwrites one that is still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | One-cycle strobe marking a new symbol decision |
| sym_quad | input | 2 | Quadrant index of the symbol, counterclockwise 0..3 |
| spec_inv | input | 1 | 1 selects the table for an inverted spectrum |
| ser_data | output | 1 | Serial decoded data |
| ser_clk | output | 1 | Recovered bit clock; data is stable on its rising edge |
| ser_valid | output | 1 | High while `ser_data` carries a decoded bit |

## Verification
The checker assumes the strobe never comes back sooner than `2*BIT_CYCLES` cycles after the previous one. It also assumes `spec_inv` is valid at the strobe edge. Under that timing the one-pair holding register can never be overrun. The stimulus tasks space strobes exactly `2*BIT_CYCLES` cycles apart, or more. They change `spec_inv` only in the same cycle as a strobe. The first symbol after every reset serves only as the phase reference and carries no expected bits.

// File: rtl/dqd_pkg.sv
package dqd_pkg;

  typedef logic [1:0] quad_t;
  typedef logic [1:0] dibit_t;

  // rotation step from previous to current quadrant, counterclockwise positive
  function automatic quad_t quad_step(input quad_t cur, input quad_t prev);
    return quad_t'(cur - prev);
  endfunction

  // step -> transmitted pair; inverted spectrum swaps the quarter-turn codes
  function automatic dibit_t step_to_dibit(input quad_t step, input logic inv);
    dibit_t d;
    unique case (step)
      2'd0: d = 2'b00;
      2'd1: d = inv ? 2'b01 : 2'b10;
      2'd2: d = 2'b11;
      default: d = inv ? 2'b10 : 2'b01;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dqd_phase_tracker.sv
module dqd_phase_tracker
  import dqd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sym_valid,
  input  quad_t  sym_quad,
  input  logic   spec_inv,
  output logic   armed,
  output logic   step_evt,
  output quad_t  step_val,
  output logic   step_inv
);

  quad_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      armed    <= 1'b0;
      step_evt <= 1'b0;
      step_val <= '0;
      step_inv <= 1'b0;
    end else begin
      step_evt <= 1'b0;
      if (sym_valid) begin
        prev_q <= sym_quad;
        armed  <= 1'b1;
        if (armed) begin
          step_evt <= 1'b1;
          step_val <= quad_step(sym_quad, prev_q);
          step_inv <= spec_inv;
        end
      end
    end
  end

endmodule

// File: rtl/dqd_pair_hold.sv
module dqd_pair_hold
  import dqd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_evt,
  input  dibit_t wr_pair,
  input  logic   take,
  output logic   full,
  output dibit_t pair
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      pair <= '0;
    end else if (wr_evt) begin
      full <= 1'b1;
      pair <= wr_pair;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/dqd_bit_shifter.sv
module dqd_bit_shifter
  import dqd_pkg::*;
#(
  parameter int BIT_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pair_ready,
  input  dibit_t pair_in,
  output logic   start_evt,
  output logic   ser_data,
  output logic   ser_clk,
  output logic   ser_valid
);

  localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] HALF = CW'(BIT_CYCLES / 2);

  logic          active;
  logic          second;
  logic [CW-1:0] cnt;
  dibit_t        shreg;
  logic          bit_end;

  assign bit_end   = active && (cnt == LAST);
  assign start_evt = pair_ready && (!active || (bit_end && second));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      second <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (start_evt) begin
      active <= 1'b1;
      second <= 1'b0;
      cnt    <= '0;
      shreg  <= pair_in;
    end else if (bit_end) begin
      cnt <= '0;
      if (!second) begin
        second <= 1'b1;
        shreg  <= {shreg[0], 1'b0};
      end else begin
        active <= 1'b0;
        second <= 1'b0;
        shreg  <= '0;
      end
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ser_data  = shreg[1];
  assign ser_valid = active;
  assign ser_clk   = active && (cnt >= HALF);

endmodule

// File: rtl/dqpsk_dibit_serializer.sv
module dqpsk_dibit_serializer
  import dqd_pkg::*;
#(
  parameter int BIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_quad,
  input  logic       spec_inv,
  output logic       ser_data,
  output logic       ser_clk,
  output logic       ser_valid
);

  // named internal events for the checker
  logic   armed;
  logic   dibit_evt;
  quad_t  step_val;
  logic   step_inv;
  dibit_t dibit_bits;
  logic   hold_full;
  dibit_t hold_bits;
  logic   start_evt;

  dqd_phase_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_quad  (sym_quad),
    .spec_inv  (spec_inv),
    .armed     (armed),
    .step_evt  (dibit_evt),
    .step_val  (step_val),
    .step_inv  (step_inv)
  );

  assign dibit_bits = step_to_dibit(step_val, step_inv);

  dqd_pair_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_evt  (dibit_evt),
    .wr_pair (dibit_bits),
    .take    (start_evt),
    .full    (hold_full),
    .pair    (hold_bits)
  );

  dqd_bit_shifter #(.BIT_CYCLES(BIT_CYCLES)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_ready (hold_full),
    .pair_in    (hold_bits),
    .start_evt  (start_evt),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk),
    .ser_valid  (ser_valid)
  );

endmodule

// File: rtl/dqd_checks.sv
module dqd_checks #(
  parameter int BIT_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sym_valid,
  input logic armed,
  input logic dibit_evt,
  input logic hold_full,
  input logic start_evt,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_valid
);

  localparam int GAP_MIN = 2 * BIT_CYCLES - 1;

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (sym_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  // R10: input rule on strobe spacing
  a_r10_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && seen) |-> (gap >= 16'(GAP_MIN)));

  // R10: a waiting pair is never overwritten
  a_r10_hold_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !start_evt) |-> !dibit_evt);

  // R4: the reference symbol yields no pair
  a_r4_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !armed) |=> !dibit_evt);

  // R7: a started pair shows up at once with the bit clock low
  a_r7_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (ser_valid && !ser_clk));

  // R6: data moves only while the bit clock is low
  a_r6_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_data != $past(ser_data)) |-> !ser_clk);

  // R9: quiet outputs when idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> (!ser_clk && !ser_data));

endmodule

bind dqpsk_dibit_serializer dqd_checks #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_valid (sym_valid),
  .armed     (armed),
  .dibit_evt (dibit_evt),
  .hold_full (hold_full),
  .start_evt (start_evt),
  .ser_data  (ser_data),
  .ser_clk   (ser_clk),
  .ser_valid (ser_valid)
);

// File: tb/dqpsk_dibit_serializer_bench.sv
module dqpsk_dibit_serializer_bench;

  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym_quad = 2'd0;
  logic       spec_inv = 1'b0;
  logic       ser_data, ser_clk, ser_valid;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  bit    m_primed = 1'b0;
  int    m_prev = 0;
  logic  last_clk = 1'b0;
  logic  last_data = 1'b0;

  always #2 clk = ~clk;

  dqpsk_dibit_serializer #(.BIT_CYCLES(B)) u_dqpsk_dibit_serializer (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_quad(sym_quad),
    .spec_inv(spec_inv), .ser_data(ser_data), .ser_clk(ser_clk), .ser_valid(ser_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // the pair a transmitter sent for a given rotation in degrees
  function automatic bit [1:0] model_pair(input int deg, input bit inv);
    if (deg == 0)   return 2'b00;
    if (deg == 180) return 2'b11;
    if (deg == 90)  return inv ? 2'b01 : 2'b10;
    return inv ? 2'b10 : 2'b01;
  endfunction

  function automatic void model_symbol(input int q, input bit inv, input string tag);
    bit [1:0] p;
    if (m_primed) begin
      p = model_pair(((q - m_prev + 4) % 4) * 90, inv);
      exp_q.push_back(p[1]); tag_q.push_back(tag);
      exp_q.push_back(p[0]); tag_q.push_back(tag);
    end
    m_primed = 1'b1;
    m_prev = q;
  endfunction

  // bit-clock rising edges: compare against the model (R5, R6)
  always @(negedge clk) begin
    if (!rst_n) begin
      last_clk  <= 1'b0;
      last_data <= 1'b0;
    end else begin
      if (ser_clk && !last_clk) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected bit", int'(ser_data), -1);
        end else begin
          chk(ser_data == exp_q[0], {"R5 ", tag_q[0]}, int'(ser_data), int'(exp_q[0]));
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          chk(ser_data == last_data, "R6 data moved across rise", int'(ser_data), int'(last_data));
        end
      end
      last_clk  <= ser_clk;
      last_data <= ser_data;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; sym_valid = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete(); tag_q.delete();
    m_primed = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int q, input bit inv, input string tag);
    @(negedge clk);
    sym_valid = 1'b1; sym_quad = 2'(q); spec_inv = inv;
    model_symbol(q, inv, tag);
    @(negedge clk);
    sym_valid = 1'b0;
    repeat (2 * B - 2) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    int k = 0;
    while ((exp_q.size() != 0 || ser_valid) && k < 200) begin
      @(negedge clk); k++;
    end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    @(negedge clk);
    chk({ser_valid, ser_clk, ser_data} == 3'b000, "R9 reset outputs",
        int'({ser_valid, ser_clk, ser_data}), 0);
    do_reset();
    chk({ser_valid, ser_clk, ser_data} == 3'b000, "R9 after reset",
        int'({ser_valid, ser_clk, ser_data}), 0);
  endtask

  task automatic t_first_silent();
    int hi = 0;
    send(2, 1'b0, "R4");
    repeat (3 * B) begin
      @(negedge clk);
      if (ser_valid) hi++;
    end
    chk(hi == 0, "R4 first symbol silent", hi, 0);
  endtask

  task automatic t_normal_table();
    // 2->2 0deg, 2->3 +90, 3->2 -90, 2->0 180, 0->1 +90, 1->0 -90, 3->0 wrap
    send(2, 1'b0, "R2 0deg");
    send(3, 1'b0, "R1 R2 +90");
    send(2, 1'b0, "R1 R2 -90");
    send(0, 1'b0, "R2 180");
    send(1, 1'b0, "R2 +90");
    send(0, 1'b0, "R2 -90");
    send(3, 1'b0, "R1 wrap -90");
    send(0, 1'b0, "R1 wrap +90");
    drain("R2 all bits out");
  endtask

  task automatic t_inverted_table();
    send(1, 1'b1, "R3 +90");
    send(0, 1'b1, "R3 -90");
    send(0, 1'b1, "R3 0deg");
    send(2, 1'b1, "R3 180");
    send(3, 1'b0, "R3 back to normal +90");
    drain("R3 all bits out");
  endtask

  task automatic t_latency();
    repeat (4) @(negedge clk);
    @(negedge clk);
    sym_valid = 1'b1; sym_quad = 2'd1; spec_inv = 1'b0;
    model_symbol(1, 1'b0, "R7 pair");
    @(negedge clk);
    sym_valid = 1'b0;
    chk(ser_valid == 1'b0, "R7 not yet after edge 1", int'(ser_valid), 0);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R7 not yet after edge 2", int'(ser_valid), 0);
    @(negedge clk);
    chk(ser_valid == 1'b1, "R7 valid after edge 3", int'(ser_valid), 1);
    chk(ser_clk == 1'b0, "R7 bit clock starts low", int'(ser_clk), 0);
    drain("R7 drain");
  endtask

  task automatic t_back_to_back();
    int run = 0;
    fork
      begin
        send(3, 1'b0, "R8 a");
        send(1, 1'b0, "R8 b");
        send(2, 1'b1, "R8 c");
        send(2, 1'b0, "R8 d");
      end
      begin
        while (!ser_valid) @(negedge clk);
        while (ser_valid) begin
          run++;
          @(negedge clk);
        end
      end
    join
    chk(run == 8 * B, "R8 unbroken stream", run, 8 * B);
    drain("R8 drain");
  endtask

  task automatic t_idle_after();
    repeat (2 * B) @(negedge clk);
    chk({ser_valid, ser_clk, ser_data} == 3'b000, "R9 idle outputs",
        int'({ser_valid, ser_clk, ser_data}), 0);
  endtask

  initial begin
    t_reset_state();
    t_first_silent();
    t_normal_table();
    t_inverted_table();
    t_latency();
    t_back_to_back();
    t_idle_after();
    do_reset();
    t_first_silent();
    send(1, 1'b0, "R4 after re-reset +90");
    drain("R4 re-reset drain");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule